// File: doc/BRIEF.md
# Edge-Aligned PWM Compare with Quarter-Cycle Trailing Edge

This block produces one edge-aligned PWM output from a free-running period counter. A fast system clock drives the block. Every fourth system clock is one instruction tick. An optional prescaler divides that tick before it reaches the counter. The output rises at the start of each period, when the counter wraps from the period value to zero. It falls when the counter reaches the compare value. A two-bit fraction code can push that falling edge later by whole system-clock periods, so the duty cycle steps in quarters of an instruction tick rather than in whole counter steps.

The mode input selects one of three behaviours. The two buffered PWM modes take the compare value and the fraction code through shadow registers at each wrap. The direct compare mode uses the compare input as it stands and applies no fractional delay. Every other mode code stops the block.

Top module: `pwm_subcycle_oc`

## Requirements
- R1: While reset is asserted, and after reset until the first counter wrap, `pwm_o` is low. The counter and shadow registers clear to zero.
- R2: An instruction tick occurs once every 4 system clocks. The counter advances once per counter tick and wraps from `period_i` back to 0, so one PWM period lasts (`period_i`+1) counter ticks. With the prescaler off this is 4·(`period_i`+1) system clocks, so the duty steps available equal `period_i`+1.
- R3: On the clock edge of a wrap, `pwm_o` goes high if the compare value is non-zero. With fraction code 0 it goes low on the clock edge of the tick at which the counter becomes equal to the compare value.
- R4: In the buffered modes (`mode_i` = 3'b110 or 3'b111), fraction code n (`frac_i`, unsigned, 0..3) delays the falling edge by n system clocks. With the prescaler off, the high time is compare·4 + n system clocks.
- R5: A compare value of 0 keeps `pwm_o` low for the whole period. A compare value greater than `period_i` keeps it high for the whole period.
- R6: In the buffered modes, changes to `compare_i` or `frac_i` during a period take effect only from the next wrap.
- R7: In direct mode (`mode_i` = 3'b001), `compare_i` is used without buffering, so a change mid-period moves the current falling edge. The fraction code has no effect.
- R8: Every other `mode_i` code (3'b000 and 3'b010 to 3'b101) holds `pwm_o` low and holds the counter and prescaler at zero. In these modes the shadow registers follow the inputs.
- R9: With `pre_en_i` high, `pre_sel_i` values 2'b00, 2'b01, 2'b10 and 2'b11 divide the instruction tick by 1, 4, 8 and 64. With `pre_en_i` low the divider is 1. The fractional delay is always counted in system clocks, even when the prescaler is on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, four per instruction tick |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_i | input | 3 | Mode: 3'b001 direct, 3'b110/3'b111 buffered PWM, all other codes stop the block |
| period_i | input | 16 | Last counter value before the wrap |
| compare_i | input | 16 | Counter value at which the output falls |
| frac_i | input | 2 | Trailing-edge delay in system clocks |
| pre_en_i | input | 1 | Enables the tick prescaler |
| pre_sel_i | input | 2 | Prescaler ratio select |
| pwm_o | output | 1 | PWM output |

## Verification
A fixed period with a fixed compare value is run under each of the four fraction codes. The measured high times show whether the trailing delay is applied per system clock or rounded to whole ticks. Compare and fraction are also changed partway through a high phase. In the buffered modes this must leave the current pulse unchanged, while in direct mode it must move the falling edge, which separates shadowed from unshadowed operation. Compare values of zero and above the period, and a period of zero, cover the saturated outputs. Each prescaler ratio is run with a non-zero fraction, to show that the delay stays in system clocks while the pulse length scales with the ratio.

// File: rtl/pwm_oc_pkg.sv
package pwm_oc_pkg;

  localparam logic [2:0] MODE_DIRECT = 3'b001;
  localparam logic [2:0] MODE_PWM_LO = 3'b110;
  localparam logic [2:0] MODE_PWM_HI = 3'b111;

  localparam int unsigned PRE_DIV_MAX = 64;

  typedef struct packed {
    logic run;       // counter and output active
    logic buffered;  // compare and fraction come from shadow registers
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [2:0] m);
    mode_dec_t d;
    d.run      = (m == MODE_DIRECT) || (m == MODE_PWM_LO) || (m == MODE_PWM_HI);
    d.buffered = (m == MODE_PWM_LO) || (m == MODE_PWM_HI);
    return d;
  endfunction

  // tick division ratio for the prescaler select
  function automatic int unsigned pre_div(input logic en, input logic [1:0] sel);
    int unsigned r;
    if (!en) r = 1;
    else begin
      case (sel)
        2'b00:   r = 1;
        2'b01:   r = 4;
        2'b10:   r = 8;
        default: r = PRE_DIV_MAX;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/pwm_oc_tick.sv
module pwm_oc_tick #(
  parameter int unsigned SUB_DIV = 4,
  parameter int unsigned PRE_MAX = pwm_oc_pkg::PRE_DIV_MAX
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       pre_en,
  input  logic [1:0] pre_sel,
  output logic       cnt_tick
);
  import pwm_oc_pkg::*;

  localparam int unsigned PC_W = (PRE_MAX > 1) ? $clog2(PRE_MAX) : 1;

  logic            itick;
  logic [PC_W-1:0] pc_q, pc_d, div_m1;

  generate
    if (SUB_DIV > 1) begin : g_phase
      localparam int unsigned PH_W = $clog2(SUB_DIV);
      localparam logic [PH_W-1:0] PH_LAST = PH_W'(SUB_DIV - 1);
      logic [PH_W-1:0] ph_q, ph_d;

      always_comb begin
        ph_d = ph_q;
        if (!run)               ph_d = '0;
        else if (ph_q == PH_LAST) ph_d = '0;
        else                    ph_d = ph_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
      end

      assign itick = run && (ph_q == PH_LAST);
    end else begin : g_nophase
      assign itick = run;
    end
  endgenerate

  assign div_m1 = PC_W'(pre_div(pre_en, pre_sel) - 1);

  always_comb begin
    pc_d = pc_q;
    if (!run)       pc_d = '0;
    else if (itick) pc_d = (pc_q >= div_m1) ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign cnt_tick = itick && (pc_q >= div_m1);

endmodule

// File: rtl/pwm_oc_timebase.sv
module pwm_oc_timebase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cnt_tick,
  input  logic [CNT_W-1:0] period_i,
  output logic             wrap,
  output logic             adv,
  output logic [CNT_W-1:0] tmr_nxt
);

  logic [CNT_W-1:0] tmr_q, tmr_d;

  assign wrap    = cnt_tick && (tmr_q == period_i);
  assign adv     = cnt_tick && !wrap;
  assign tmr_nxt = (tmr_q == period_i) ? '0 : tmr_q + 1'b1;

  always_comb begin
    tmr_d = tmr_q;
    if (!run)          tmr_d = '0;
    else if (cnt_tick) tmr_d = tmr_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

endmodule

// File: rtl/pwm_oc_shadow.sv
module pwm_oc_shadow #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned FRAC_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  cmp_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [CNT_W-1:0]  cmp_q,
  output logic [FRAC_W-1:0] frac_q
);

  logic [CNT_W-1:0]  cmp_d;
  logic [FRAC_W-1:0] frac_d;

  always_comb begin
    cmp_d  = cmp_q;
    frac_d = frac_q;
    if (load) begin
      cmp_d  = cmp_i;
      frac_d = frac_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      frac_q <= '0;
    end else begin
      cmp_q  <= cmp_d;
      frac_q <= frac_d;
    end
  end

endmodule

// File: rtl/pwm_oc_edge.sv
module pwm_oc_edge #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned FRAC_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wrap,
  input  logic              adv,
  input  logic [CNT_W-1:0]  tmr_nxt,
  input  logic [CNT_W-1:0]  cmp_eff,
  input  logic [FRAC_W-1:0] frac_eff,
  input  logic [CNT_W-1:0]  cmp_new,
  output logic              pwm_o
);

  logic              out_q, out_d;
  logic [FRAC_W-1:0] dly_q, dly_d;
  logic              match;

  assign match = adv && (tmr_nxt == cmp_eff);

  always_comb begin
    out_d = out_q;
    dly_d = dly_q;
    if (!run) begin
      out_d = 1'b0;
      dly_d = '0;
    end else begin
      if (dly_q != '0) begin
        dly_d = dly_q - 1'b1;
        if (dly_q == FRAC_W'(1)) out_d = 1'b0;
      end
      if (wrap) begin
        out_d = |cmp_new;
        dly_d = '0;
      end else if (match) begin
        if (frac_eff == '0) out_d = 1'b0;
        else                dly_d = frac_eff;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      dly_q <= '0;
    end else begin
      out_q <= out_d;
      dly_q <= dly_d;
    end
  end

  assign pwm_o = out_q;

endmodule

// File: rtl/pwm_subcycle_oc.sv
module pwm_subcycle_oc #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned SUB_DIV = 4,
  parameter int unsigned PRE_MAX = pwm_oc_pkg::PRE_DIV_MAX,
  localparam int unsigned FRAC_W = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [CNT_W-1:0]  compare_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              pre_en_i,
  input  logic [1:0]        pre_sel_i,
  output logic              pwm_o
);
  import pwm_oc_pkg::*;

  logic [1:0]        sync_q;
  logic              rst_int_n;
  mode_dec_t         md;
  logic              cnt_tick, wrap, adv, load;
  logic [CNT_W-1:0]  tmr_nxt, cmp_q, cmp_eff;
  logic [FRAC_W-1:0] frac_q, frac_eff;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_int_n = sync_q[1];

  assign md = decode_mode(mode_i);

  pwm_oc_tick #(.SUB_DIV(SUB_DIV), .PRE_MAX(PRE_MAX)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .run(md.run),
    .pre_en(pre_en_i), .pre_sel(pre_sel_i), .cnt_tick(cnt_tick)
  );

  pwm_oc_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_int_n), .run(md.run), .cnt_tick(cnt_tick),
    .period_i(period_i), .wrap(wrap), .adv(adv), .tmr_nxt(tmr_nxt)
  );

  assign load = !md.run || (wrap && md.buffered);

  pwm_oc_shadow #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_shadow (
    .clk(clk), .rst_n(rst_int_n), .load(load),
    .cmp_i(compare_i), .frac_i(frac_i), .cmp_q(cmp_q), .frac_q(frac_q)
  );

  assign cmp_eff  = md.buffered ? cmp_q  : compare_i;
  assign frac_eff = md.buffered ? frac_q : '0;

  pwm_oc_edge #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_edge (
    .clk(clk), .rst_n(rst_int_n), .run(md.run), .wrap(wrap), .adv(adv),
    .tmr_nxt(tmr_nxt), .cmp_eff(cmp_eff), .frac_eff(frac_eff),
    .cmp_new(compare_i), .pwm_o(pwm_o)
  );

endmodule

// File: rtl/pwm_subcycle_oc_chk.sv
module pwm_subcycle_oc_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned FRAC_W = 2
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              run,
  input logic              buffered,
  input logic              cnt_tick,
  input logic              wrap,
  input logic              adv,
  input logic [CNT_W-1:0]  tmr_nxt,
  input logic [CNT_W-1:0]  compare_i,
  input logic [CNT_W-1:0]  cmp_q,
  input logic [FRAC_W-1:0] frac_q,
  input logic              pwm_o
);

  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_int_n)
    cnt_tick |=> !cnt_tick);

  a_r3_rise_on_wrap: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wrap && compare_i != '0) |=> pwm_o);

  a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wrap && compare_i == '0) |=> !pwm_o);

  a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (run && buffered && !wrap) |=> ($stable(cmp_q) && $stable(frac_q)));

  a_r7_direct_fall: assert property (@(posedge clk) disable iff (!rst_int_n)
    (run && !buffered && adv && tmr_nxt == compare_i) |=> !pwm_o);

  a_r8_stopped_low: assert property (@(posedge clk) disable iff (!rst_int_n)
    !run |=> !pwm_o);

endmodule

bind pwm_subcycle_oc pwm_subcycle_oc_chk #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .run(md.run), .buffered(md.buffered),
  .cnt_tick(cnt_tick), .wrap(wrap), .adv(adv), .tmr_nxt(tmr_nxt),
  .compare_i(compare_i), .cmp_q(cmp_q), .frac_q(frac_q), .pwm_o(pwm_o)
);

// File: tb/tb_pwm_subcycle_oc.sv
`timescale 1ns/1ps
module tb_pwm_subcycle_oc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [2:0]  mode_i = 3'b000;
  logic [15:0] period_i = 16'd9;
  logic [15:0] compare_i = 16'd4;
  logic [1:0]  frac_i = 2'b00;
  logic        pre_en_i = 1'b0;
  logic [1:0]  pre_sel_i = 2'b00;
  logic        pwm_o;

  int    n_chk = 0, n_err = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  pwm_subcycle_oc dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .period_i(period_i),
    .compare_i(compare_i), .frac_i(frac_i), .pre_en_i(pre_en_i),
    .pre_sel_i(pre_sel_i), .pwm_o(pwm_o)
  );

  // ---------------- behavioural reference ----------------
  int m_ph, m_pc, m_tmr, m_cmp, m_frac, m_dly;
  bit m_out, m_r1, m_r2, m_valid = 1'b0;

  function automatic int ratio(bit en, int sel);
    if (!en) return 1;
    case (sel)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 64;
    endcase
  endfunction

  task automatic model_step();
    bit run, buf_m, it, ct;
    int div, ceff, d;
    run   = (mode_i == 3'b001) || (mode_i == 3'b110) || (mode_i == 3'b111);
    buf_m = mode_i[2];
    if (!run) begin
      m_ph = 0; m_pc = 0; m_tmr = 0; m_out = 0; m_dly = 0;
      m_cmp = compare_i; m_frac = frac_i;
      return;
    end
    it   = (m_ph == 3);
    m_ph = (m_ph + 1) % 4;
    div  = ratio(pre_en_i, pre_sel_i);
    ct   = it && (m_pc >= div - 1);
    if (it) m_pc = (m_pc >= div - 1) ? 0 : m_pc + 1;
    ceff = buf_m ? m_cmp : int'(compare_i);
    d    = buf_m ? m_frac : 0;
    if (m_dly != 0) begin
      if (m_dly == 1) m_out = 0;
      m_dly--;
    end
    if (ct) begin
      if (m_tmr == int'(period_i)) begin
        m_tmr = 0;
        if (buf_m) begin m_cmp = compare_i; m_frac = frac_i; end
        m_out = (compare_i != 0);
        m_dly = 0;
      end else begin
        m_tmr++;
        if (m_tmr == ceff) begin
          if (d == 0) m_out = 0;
          else        m_dly = d;
        end
      end
    end
  endtask

  always @(posedge clk) begin
    bit ok;
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; m_ph = 0; m_pc = 0; m_tmr = 0;
      m_cmp = 0; m_frac = 0; m_dly = 0; m_out = 0; m_valid = 1;
    end else begin
      ok = m_r2; m_r2 = m_r1; m_r1 = 1;
      if (ok) model_step();
    end
  end

  always @(negedge clk) begin
    if (m_valid && !done) begin
      n_chk++;
      if (pwm_o !== m_out) begin
        n_err++;
        $display("FAIL %s model compare at %0t: pwm_o=%0d expected %0d", cur_req, $time, pwm_o, m_out);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(input logic [2:0] m, input int per, input int cmp, input int f,
                       input bit pe, input int ps);
    @(negedge clk);
    mode_i = 3'b000;
    repeat (2) @(negedge clk);
    period_i = 16'(per); compare_i = 16'(cmp); frac_i = 2'(f);
    pre_en_i = pe; pre_sel_i = 2'(ps);
    @(negedge clk);
    mode_i = m;
  endtask

  task automatic wait_rise();
    do @(negedge clk); while (pwm_o !== 1'b0);
    do @(negedge clk); while (pwm_o !== 1'b1);
  endtask

  task automatic measure_high(output int n);
    wait_rise();
    n = 0;
    while (pwm_o === 1'b1) begin n++; @(negedge clk); end
  endtask

  task automatic measure_period(output int n);
    wait_rise();
    n = 0;
    do begin n++; @(negedge clk); end while (pwm_o === 1'b1);
    do begin n++; @(negedge clk); end while (pwm_o === 1'b0);
  endtask

  task automatic count_high(input int win, output int n);
    n = 0;
    repeat (win) begin @(negedge clk); if (pwm_o === 1'b1) n++; end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int n;
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(pwm_o === 1'b0, "R1 low in reset", int'(pwm_o), 0);
    rst_n = 1'b1;

    // R1: low after reset until first wrap (first wrap takes 40+ clocks)
    cur_req = "R1";
    @(negedge clk); mode_i = 3'b110;
    count_high(20, n);
    chk(n == 0, "R1 low before first wrap", n, 0);

    // R2: period length and resolution
    cur_req = "R2";
    start(3'b110, 9, 4, 0, 0, 0);
    measure_period(n);
    chk(n == 40, "R2 period 9", n, 40);
    start(3'b110, 31, 4, 0, 0, 0);
    measure_period(n);
    chk(n == 128, "R2 period 31", n, 128);

    // R3 / R4: each fraction code
    for (int f = 0; f < 4; f++) begin
      cur_req = "R4";
      start(3'b110, 9, 4, f, 0, 0);
      measure_high(n);
      chk(n == 16 + f, (f == 0) ? "R3 fall on match" : "R4 quarter delay", n, 16 + f);
    end
    start(3'b111, 9, 6, 2, 0, 0);
    measure_high(n);
    chk(n == 26, "R4 mode 111 delay", n, 26);

    // R6: mid-pulse change held until next wrap
    cur_req = "R6";
    start(3'b110, 9, 4, 0, 0, 0);
    wait_rise();
    n = 0;
    repeat (4) begin n++; @(negedge clk); end
    compare_i = 16'd7; frac_i = 2'd3;
    while (pwm_o === 1'b1) begin n++; @(negedge clk); end
    chk(n == 16, "R6 current pulse unchanged", n, 16);
    measure_high(n);
    chk(n == 31, "R6 next pulse updated", n, 31);

    // R7: direct mode, fraction ignored, compare live
    cur_req = "R7";
    start(3'b001, 9, 4, 3, 0, 0);
    measure_high(n);
    chk(n == 16, "R7 fraction ignored", n, 16);
    wait_rise();
    n = 0;
    repeat (4) begin n++; @(negedge clk); end
    compare_i = 16'd7;
    while (pwm_o === 1'b1) begin n++; @(negedge clk); end
    chk(n == 28, "R7 live compare", n, 28);

    // R5: saturated outputs
    cur_req = "R5";
    start(3'b110, 9, 0, 2, 0, 0);
    count_high(120, n);
    chk(n == 0, "R5 compare zero", n, 0);
    start(3'b110, 9, 12, 1, 0, 0);
    wait_rise();
    count_high(100, n);
    chk(n == 100, "R5 compare above period", n, 100);
    start(3'b110, 0, 1, 0, 0, 0);
    wait_rise();
    count_high(60, n);
    chk(n == 60, "R5 period zero", n, 60);

    // R8: stopped mode codes
    cur_req = "R8";
    for (int m = 0; m < 8; m++) begin
      if (m == 1 || m == 6 || m == 7) continue;
      start(3'(m), 9, 4, 1, 0, 0);
      count_high(60, n);
      chk(n == 0, "R8 stopped mode low", n, 0);
    end

    // R9: prescaler ratios, fraction stays in system clocks
    cur_req = "R9";
    for (int s = 0; s < 4; s++) begin
      start(3'b110, 3, 2, 2, 1, s);
      measure_high(n);
      chk(n == 8 * ratio(1, s) + 2, "R9 prescaled high time", n, 8 * ratio(1, s) + 2);
    end
    start(3'b110, 3, 2, 2, 0, 3);
    measure_high(n);
    chk(n == 10, "R9 prescaler disabled", n, 10);

    done = 1'b1;
    finish_run();
  end

endmodule